// File: doc/BRIEF.md
# Bit-Serial Signed and Unsigned Magnitude Comparator

This block compares two operands that arrive one bit per clock, least significant bit first. It keeps three running relations over the bits seen so far: whether the operands are equal, whether the first operand is below the second when both are read as unsigned numbers, and whether the first operand is below the second when both are read as two's-complement numbers. The signed relation is final only once the bit flagged as the sign bit has been taken in.

A stream begins with a clear pulse. Each operand bit is presented with a qualifying strobe. The operand width is not fixed in hardware; it is set only by the bit that carries the end flag. Equality and unsigned order each need one state bit. On the flagged bit, a small multiplexer corrects the unsigned order for the sign. The multiplexer is steered by the unsigned order of the lower bits. Greater-than and the other relations come from swapping the operands outside the block.

Top module: `bit_serial_cmp`

## Requirements
- R1: A bit pair is taken in on a rising clock edge where `valid` is high. All three outputs show the result that includes that pair from the next cycle onward. Bit i of an operand is the i-th accepted pair after a clear, with bit 0 being the least significant.
- R2: `eq` is 1 exactly when every accepted pair since the last clear had `bit_a == bit_b`. Once `eq` is 0 it stays 0 until a clear.
- R3: `ult` is 1 exactly when the accepted low bits of A, read as an unsigned number, are less than those of B. A pair with `bit_a != bit_b` sets `ult` to `bit_b`. An equal pair leaves `ult` unchanged.
- R4: After an accepted pair with `last` high, `slt` is 1 exactly when A is less than B, with both read as two's-complement numbers of the accepted width. If the sign bits differ, `slt` equals `bit_a`. If they match, `slt` equals the unsigned order of the lower bits.
- R5: `start` high clears the state to `eq`=1, `ult`=0, `slt`=0. If `valid` is also high in that cycle, the pair is taken in as bit 0 of a new operand.
- R6: In a cycle with `valid` and `start` both low, all outputs hold their values, whatever `bit_a`, `bit_b` and `last` do.
- R7: For a 1-bit operand (bit 0 carries `last`), `slt` becomes `bit_a & ~bit_b` and `ult` becomes `~bit_a & bit_b`.
- R8: After reset, `eq`=1, `ult`=0 and `slt`=0.
- R9: After an accepted pair with `last` low, `slt` equals `ult`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clear pulse that begins a new comparison |
| valid | input | 1 | Qualifies `bit_a`, `bit_b` and `last` |
| bit_a | input | 1 | Current bit of operand A |
| bit_b | input | 1 | Current bit of operand B |
| last | input | 1 | Marks the current pair as the sign bit |
| eq | output | 1 | A equals B over the bits so far |
| ult | output | 1 | A below B, unsigned, over the bits so far |
| slt | output | 1 | A below B, signed; final after the sign bit |

## Verification
Each output is registered exactly once, so every result is due one clock after the edge that accepts its pair, and a clear shows one clock after its edge. The bench drives inputs on the falling edge. It reads the outputs at the next falling edge, after the one rising edge that takes in the pair. Idle gaps are read the same way: one falling edge later, with the previous expectation still in force.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    // Two-state recurrence for the unsigned order of the low bits.
    typedef enum logic {
        ORD_NOT_BELOW = 1'b0,
        ORD_BELOW     = 1'b1
    } ord_e;

    typedef struct packed {
        logic eq;
        ord_e ult;
        logic slt;
    } cmp_state_t;

    localparam cmp_state_t CMP_CLEARED = '{eq: 1'b1, ult: ORD_NOT_BELOW, slt: 1'b0};

endpackage

// File: rtl/bsc_eq_track.sv
module bsc_eq_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic bit_a,
    input  logic bit_b,
    output logic eq_q
);

    logic eq_d;
    logic base;

    always_comb begin
        base = clr ? 1'b1 : eq_q;
        eq_d = base;
        if (step) begin
            eq_d = base & ~(bit_a ^ bit_b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_q <= 1'b1;
        end else begin
            eq_q <= eq_d;
        end
    end

    AST_EQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !eq_q) |=> !eq_q); // R2

    AST_EQ_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (bit_a != bit_b)) |=> !eq_q); // R2

endmodule

// File: rtl/bsc_ult_track.sv
module bsc_ult_track
    import bsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic bit_a,
    input  logic bit_b,
    output ord_e ult_prior,
    output ord_e ult_next,
    output ord_e ult_q
);

    ord_e ult_d;

    always_comb begin
        ult_prior = clr ? ORD_NOT_BELOW : ult_q;
        // Current pair decides unless equal; then the prior order stands.
        ult_next  = ord_e'((~bit_a & bit_b) | (~(bit_a & ~bit_b) & ult_prior));
        ult_d     = step ? ult_next : ult_prior;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ult_q <= ORD_NOT_BELOW;
        end else begin
            ult_q <= ult_d;
        end
    end

    AST_ULT_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (bit_a != bit_b)) |=> (ult_q == ord_e'($past(bit_b)))); // R3

    AST_ULT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && (bit_a == bit_b)) |=> $stable(ult_q)); // R3

endmodule

// File: rtl/bsc_sign_fix.sv
module bsc_sign_fix
    import bsc_pkg::*;
(
    input  ord_e ult_prior,
    input  ord_e ult_next,
    input  logic bit_a,
    input  logic bit_b,
    input  logic last,
    output logic slt_next
);

    logic sign_below;

    always_comb begin
        // Sign pair: prior order selects the OR or AND form.
        sign_below = (ult_prior == ORD_BELOW) ? (bit_a | ~bit_b) : (bit_a & ~bit_b);
        slt_next   = last ? sign_below : logic'(ult_next);
    end

    always_comb begin
        if (last && (bit_a != bit_b)) begin
            AST_SIGN_DIFF: assert (slt_next == bit_a); // R4
        end
    end

endmodule

// File: rtl/bit_serial_cmp.sv
module bit_serial_cmp
    import bsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic valid,
    input  logic bit_a,
    input  logic bit_b,
    input  logic last,
    output logic eq,
    output logic ult,
    output logic slt
);

    ord_e ult_prior;
    ord_e ult_next;
    ord_e ult_q;
    logic eq_q;
    logic slt_next;

    typedef struct packed {
        logic slt;
    } top_reg_t;

    top_reg_t r_d;
    top_reg_t r_q;

    bsc_eq_track u_eq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .step  (valid),
        .bit_a (bit_a),
        .bit_b (bit_b),
        .eq_q  (eq_q)
    );

    bsc_ult_track u_ult (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .step      (valid),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .ult_prior (ult_prior),
        .ult_next  (ult_next),
        .ult_q     (ult_q)
    );

    bsc_sign_fix u_sign (
        .ult_prior (ult_prior),
        .ult_next  (ult_next),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .last      (last),
        .slt_next  (slt_next)
    );

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.slt = CMP_CLEARED.slt;
        end
        if (valid) begin
            r_d.slt = slt_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.slt <= CMP_CLEARED.slt;
        end else begin
            r_q <= r_d;
        end
    end

    assign eq  = eq_q;
    assign ult = logic'(ult_q);
    assign slt = r_q.slt;

    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !valid) |=> (eq && !ult && !slt)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !valid) |=> ($stable(eq) && $stable(ult) && $stable(slt))); // R6

    AST_EQ_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        eq |-> (!ult && !slt)); // R3

    AST_BODY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last) |=> (slt == ult)); // R9

    AST_SIGN_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && last && (bit_a != bit_b)) |=> (slt == $past(bit_a))); // R4

endmodule

// File: tb/tb_bit_serial_cmp.sv
module tb_bit_serial_cmp;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic valid = 1'b0;
    logic bit_a = 1'b0;
    logic bit_b = 1'b0;
    logic last = 1'b0;
    logic eq;
    logic ult;
    logic slt;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    bit_serial_cmp dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .valid (valid),
        .bit_a (bit_a),
        .bit_b (bit_b),
        .last  (last),
        .eq    (eq),
        .ult   (ult),
        .slt   (slt)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic e_eq, input logic e_ult, input logic e_slt);
        chk(req, "eq", eq, e_eq);
        chk(req, "ult", ult, e_ult);
        chk(req, "slt", slt, e_slt);
    endtask

    // mode 0: start with bit 0; mode 1: separate start pulse; mode 2: start with bit 0 plus an idle gap
    task automatic run_pair(input int w, input int A, input int B, input int mode);
        logic e_eq, e_ult, e_slt;
        if (mode == 1) begin
            start = 1'b1; valid = 1'b0; bit_a = ~bit_a; last = 1'b1;
            @(negedge clk);
            chk_all("R5", 1'b1, 1'b0, 1'b0);
        end
        for (int i = 0; i < w; i++) begin
            int m;
            int sa;
            int sb;
            start = (i == 0) && (mode != 1);
            valid = 1'b1;
            bit_a = A[i];
            bit_b = B[i];
            last  = (i == w - 1);
            @(negedge clk);
            m = (1 << (i + 1)) - 1;
            e_eq  = ((A & m) == (B & m));
            e_ult = ((A & m) < (B & m));
            if (i == w - 1) begin
                sa = (A & m) ^ (1 << i);
                sb = (B & m) ^ (1 << i);
                e_slt = (sa < sb);
                if (w == 1) begin
                    chk("R7", "slt", slt, A[0] & ~B[0]);
                    chk("R7", "ult", ult, ~A[0] & B[0]);
                end
                chk("R4", "slt", slt, e_slt);
            end else begin
                e_slt = e_ult;
                chk("R9", "slt", slt, e_slt);
            end
            chk("R1", "eq", eq, e_eq);
            chk("R2", "eq", eq, e_eq);
            chk("R3", "ult", ult, e_ult);
            if (mode == 2 && i == w / 2) begin
                start = 1'b0; valid = 1'b0;
                bit_a = ~bit_a; bit_b = bit_a ^ 1'b1; last = ~last;
                @(negedge clk);
                chk_all("R6", e_eq, e_ult, e_slt);
                bit_a = ~bit_a;
                @(negedge clk);
                chk_all("R6", e_eq, e_ult, e_slt);
            end
        end
        start = 1'b0; valid = 1'b0; last = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R8", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R8", 1'b1, 1'b0, 1'b0);
        for (int w = 1; w <= 4; w++) begin
            for (int A = 0; A < (1 << w); A++) begin
                for (int B = 0; B < (1 << w); B++) begin
                    run_pair(w, A, B, (A + B) % 3);
                end
            end
        end
        for (int A = 0; A < 256; A++) begin
            for (int B = 0; B < 256; B += 7) begin
                run_pair(8, A, B, (A + B) % 3);
            end
            run_pair(8, A, A, A % 3);
            run_pair(8, A, 255, 1);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule